// File: doc/BRIEF.md
# Non-Idempotent-Safe Instruction Fetch Sequencer

This block sits between the program counter and the request port of an instruction cache, and pushes the returned instructions into an instruction queue. It has at most one fetch in flight. Each request carries a speculation flag. The flag is raised once a branch instruction has been accepted into the queue, and it stays up until that branch resolves or the front end is redirected. When a response comes back while the queue cannot take it, the sequencer keeps the fetch address. It then reissues the same fetch once the queue reports ready again.

Address regions that must not be read twice or read speculatively get stricter handling. A region lookup outside the block reports whether the current fetch address is one of these regions. For such an address the sequencer issues the request only when two conditions hold. The speculation flag must be clear. The queue's free-entry count, after subtracting the entries already reserved for fetches in flight, must leave room for the result. Such a fetch can therefore never be replayed, and it never reaches the cache with the speculation flag set.

A replay cannot stall a refetch forever, because only a branch that actually lands in the queue raises the speculation flag. A branch that is itself replayed leaves the flag unchanged. Fetches to ordinary regions are issued without any gating, speculatively when the flag is up, and may be replayed freely.

Top module: `nifetch_ctrl`

## Requirements
- R1: After reset and until the first redirect, `req_valid_o` and `q_push_o` stay low.
- R2: A response taken while `q_ready_i` is high is pushed in the same cycle with its fetch address on `q_pc_o` and its data on `q_instr_o`. The next request is then made to that address plus 4.
- R3: Once a response with `rsp_is_branch_i` high has been pushed, every later request has `req_spec_o` high. This lasts until a cycle with `br_resolve_i` high, after which requests have `req_spec_o` low.
- R4: No request is raised for an address with `ni_region_i` high while the speculation flag is set. Such a fetch waits, and is issued with `req_spec_o` low after the branch resolves.
- R5: No request is raised for an address with `ni_region_i` high unless `q_free_i` exceeds the number of entries already reserved for fetches in flight. In particular, nothing is raised while `q_free_i` is 0.
- R6: A response that arrives while `q_ready_i` is low is not pushed. The same address is requested again only after `q_ready_i` has returned high, and that instruction is pushed exactly once.
- R7: A branch response that is replayed does not raise the speculation flag, so its refetch has `req_spec_o` low.
- R8: A redirect replaces the pending fetch address and clears the speculation flag. The response of a request already issued is discarded and never pushed. The next request goes to the redirect address.
- R9: At most one request is in flight at a time. Each non-idempotent address is requested once per pushed instruction.
- R10: Requests to addresses with `ni_region_i` low are raised regardless of `q_free_i`, including when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| redirect_valid_i | input | 1 | Start or restart fetch at `redirect_pc_i` |
| redirect_pc_i | input | ADDR_W | Restart address |
| br_resolve_i | input | 1 | The outstanding branch has resolved |
| req_valid_o | output | 1 | Fetch request to the cache |
| req_ready_i | input | 1 | Cache accepts the request |
| req_addr_o | output | ADDR_W | Fetch address |
| req_spec_o | output | 1 | Request is speculative |
| ni_region_i | input | 1 | `req_addr_o` lies in a non-idempotent region |
| rsp_valid_i | input | 1 | Cache returns the instruction |
| rsp_instr_i | input | INSTR_W | Returned instruction |
| rsp_is_branch_i | input | 1 | Returned instruction is a branch |
| q_ready_i | input | 1 | Queue can take a push this cycle |
| q_free_i | input | FREE_W | Free queue entries |
| q_push_o | output | 1 | Push into the queue |
| q_pc_o | output | ADDR_W | Address of the pushed instruction |
| q_instr_o | output | INSTR_W | Pushed instruction |

## Verification
The bench builds the block with 32-bit addresses and instructions and a 3-bit free count, with a cache model that answers two cycles after acceptance. The cache model refuses any speculative request to a non-idempotent address. Any such request would therefore stall the run visibly instead of only being counted. The 3-bit count lets the bench hold the free count at 0 to block non-idempotent fetches, then release it at 1 to admit exactly one. The two-cycle latency leaves a cycle in which a redirect can overtake a response still in flight.

// File: rtl/nf_pkg.sv
package nf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_HOLD,
        ST_DRAIN
    } fstate_e;
endpackage

// File: rtl/nf_spec.sv
module nf_spec (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic resolve_i,
    input  logic flush_i,
    output logic spec_o
);
    typedef struct packed {
        logic spec;
    } spec_t;

    spec_t q, d;

    always_comb begin
        d = q;
        if (flush_i)        d.spec = 1'b0;
        else if (set_i)     d.spec = 1'b1;
        else if (resolve_i) d.spec = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{spec: 1'b0};
        else         q <= d;
    end

    assign spec_o = q.spec;

    assert_resolve_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (resolve_i && !set_i) |=> !spec_o);
    assert_branch_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i && !flush_i) |=> spec_o);
    assert_flush_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> !spec_o);
endmodule

// File: rtl/nf_credit.sv
module nf_credit #(
    parameter int FREE_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [FREE_W-1:0] q_free_i,
    input  logic              take_i,
    input  logic              give_i,
    output logic              room_o
);
    typedef struct packed {
        logic [FREE_W-1:0] resv;
    } cred_t;

    cred_t q, d;

    always_comb begin
        d = q;
        if (take_i && !give_i)      d.resv = q.resv + 1'b1;
        else if (give_i && !take_i) d.resv = q.resv - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{resv: '0};
        else         q <= d;
    end

    assign room_o = q_free_i > q.resv;

    assert_no_underflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (give_i && !take_i) |-> (q.resv != '0));
    assert_single_ni_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        take_i |-> (q.resv == '0));
endmodule

// File: rtl/nf_seq.sv
module nf_seq
    import nf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int STEP_BYTES = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              redirect_i,
    input  logic [ADDR_W-1:0] redirect_pc_i,
    input  logic              ni_region_i,
    input  logic              spec_i,
    input  logic              ni_room_i,
    input  logic              req_ready_i,
    input  logic              rsp_valid_i,
    input  logic              q_ready_i,
    output logic              req_valid_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic              q_push_o,
    output logic [ADDR_W-1:0] push_pc_o,
    output logic              ni_take_o,
    output logic              ni_give_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STEP_BYTES);

    typedef struct packed {
        fstate_e           st;
        logic [ADDR_W-1:0] pc;
        logic              ni;
    } seq_t;

    seq_t q, d;
    logic gate_ok;
    logic req_v;
    logic push;
    logic take;
    logic give;

    always_comb begin
        d       = q;
        push    = 1'b0;
        take    = 1'b0;
        give    = 1'b0;
        gate_ok = !ni_region_i || (!spec_i && ni_room_i);
        req_v   = (q.st == ST_REQ) && !redirect_i && gate_ok;
        unique case (q.st)
            ST_IDLE: ;
            ST_REQ: begin
                if (req_v && req_ready_i) begin
                    d.st = ST_WAIT;
                    d.ni = ni_region_i;
                    take = ni_region_i;
                end
            end
            ST_WAIT: begin
                if (rsp_valid_i) begin
                    give = q.ni;
                    d.ni = 1'b0;
                    if (!redirect_i) begin
                        if (q_ready_i) begin
                            push = 1'b1;
                            d.pc = q.pc + STEP;
                            d.st = ST_REQ;
                        end else begin
                            d.st = ST_HOLD;
                        end
                    end
                end
            end
            ST_HOLD: begin
                if (q_ready_i) d.st = ST_REQ;
            end
            ST_DRAIN: begin
                if (rsp_valid_i) begin
                    give = q.ni;
                    d.ni = 1'b0;
                    d.st = ST_REQ;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (redirect_i) begin
            d.pc = redirect_pc_i;
            if ((q.st == ST_WAIT || q.st == ST_DRAIN) && !rsp_valid_i) d.st = ST_DRAIN;
            else                                                       d.st = ST_REQ;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{st: ST_IDLE, pc: '0, ni: 1'b0};
        else         q <= d;
    end

    assign req_valid_o = req_v;
    assign req_addr_o  = q.pc;
    assign q_push_o    = push;
    assign push_pc_o   = q.pc;
    assign ni_take_o   = take;
    assign ni_give_o   = give;

    assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_IDLE) |-> (!req_valid_o && !q_push_o));
    assert_one_outstanding_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st inside {ST_WAIT, ST_DRAIN}) |-> !req_valid_o);
    assert_hold_keeps_pc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_HOLD && !redirect_i) |=> $stable(req_addr_o));
    assert_push_advances_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q_push_o && !redirect_i) |=> (req_addr_o == $past(push_pc_o) + STEP));
    assert_no_push_on_redirect_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_i |-> !q_push_o);
endmodule

// File: rtl/nifetch_ctrl.sv
module nifetch_ctrl #(
    parameter int ADDR_W     = 32,
    parameter int INSTR_W    = 32,
    parameter int FREE_W     = 4,
    parameter int STEP_BYTES = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               redirect_valid_i,
    input  logic [ADDR_W-1:0]  redirect_pc_i,
    input  logic               br_resolve_i,
    output logic               req_valid_o,
    input  logic               req_ready_i,
    output logic [ADDR_W-1:0]  req_addr_o,
    output logic               req_spec_o,
    input  logic               ni_region_i,
    input  logic               rsp_valid_i,
    input  logic [INSTR_W-1:0] rsp_instr_i,
    input  logic               rsp_is_branch_i,
    input  logic               q_ready_i,
    input  logic [FREE_W-1:0]  q_free_i,
    output logic               q_push_o,
    output logic [ADDR_W-1:0]  q_pc_o,
    output logic [INSTR_W-1:0] q_instr_o
);
    logic spec;
    logic room;
    logic take;
    logic give;
    logic push;

    nf_seq #(
        .ADDR_W    (ADDR_W),
        .STEP_BYTES(STEP_BYTES)
    ) seq_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .redirect_i   (redirect_valid_i),
        .redirect_pc_i(redirect_pc_i),
        .ni_region_i  (ni_region_i),
        .spec_i       (spec),
        .ni_room_i    (room),
        .req_ready_i  (req_ready_i),
        .rsp_valid_i  (rsp_valid_i),
        .q_ready_i    (q_ready_i),
        .req_valid_o  (req_valid_o),
        .req_addr_o   (req_addr_o),
        .q_push_o     (push),
        .push_pc_o    (q_pc_o),
        .ni_take_o    (take),
        .ni_give_o    (give)
    );

    nf_spec spec_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_i    (push && rsp_is_branch_i),
        .resolve_i(br_resolve_i),
        .flush_i  (redirect_valid_i),
        .spec_o   (spec)
    );

    nf_credit #(
        .FREE_W(FREE_W)
    ) credit_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .q_free_i(q_free_i),
        .take_i  (take),
        .give_i  (give),
        .room_o  (room)
    );

    assign req_spec_o = spec;
    assign q_push_o   = push;
    assign q_instr_o  = rsp_instr_i;

    assert_ni_not_spec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_o && ni_region_i) |-> !req_spec_o);
    assert_ni_has_room_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_o && ni_region_i) |-> (q_free_i != '0));
    assert_push_when_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q_push_o |-> (q_ready_i && rsp_valid_i));
endmodule

// File: tb/nifetch_ctrl_tb_top.sv
module nifetch_ctrl_tb_top;
    localparam int AW = 32;
    localparam int IW = 32;
    localparam int FW = 3;
    localparam int LAT = 2;
    localparam logic [31:0] NI_BASE = 32'h8000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          redirect_valid = 1'b0;
    logic [AW-1:0] redirect_pc = '0;
    logic          br_resolve = 1'b0;
    logic          req_valid;
    logic          req_ready;
    logic [AW-1:0] req_addr;
    logic          req_spec;
    logic          ni_region;
    logic          rsp_valid = 1'b0;
    logic [IW-1:0] rsp_instr = '0;
    logic          rsp_is_branch = 1'b0;
    logic          q_ready = 1'b1;
    logic [FW-1:0] q_free = 3'd4;
    logic          q_push;
    logic [AW-1:0] q_pc;
    logic [IW-1:0] q_instr;

    logic          cache_en = 1'b0;
    logic [31:0]   branch_addr = 32'h1;

    assign ni_region = req_addr[31];
    assign req_ready = cache_en && !(ni_region && req_spec);

    nifetch_ctrl #(.ADDR_W(AW), .INSTR_W(IW), .FREE_W(FW), .STEP_BYTES(4)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .redirect_valid_i(redirect_valid), .redirect_pc_i(redirect_pc),
        .br_resolve_i(br_resolve),
        .req_valid_o(req_valid), .req_ready_i(req_ready),
        .req_addr_o(req_addr), .req_spec_o(req_spec), .ni_region_i(ni_region),
        .rsp_valid_i(rsp_valid), .rsp_instr_i(rsp_instr), .rsp_is_branch_i(rsp_is_branch),
        .q_ready_i(q_ready), .q_free_i(q_free),
        .q_push_o(q_push), .q_pc_o(q_pc), .q_instr_o(q_instr)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    int push_n = 0;
    int req_n = 0;
    int spec_viol = 0;
    int outst_viol = 0;
    int data_viol = 0;
    logic [31:0] push_log [64];
    logic [31:0] req_log [64];
    logic        spec_log [64];

    function automatic logic [31:0] instr_of(logic [31:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction

    // Cache and queue observer
    initial begin
        bit pend = 1'b0;
        int cnt = 0;
        logic [31:0] paddr = '0;
        logic [31:0] raddr = '0;
        forever begin
            @(negedge clk);
            rsp_valid = 1'b0;
            rsp_is_branch = 1'b0;
            if (rst_n && pend) begin
                if (cnt == 0) begin
                    rsp_valid = 1'b1;
                    rsp_instr = instr_of(paddr);
                    rsp_is_branch = (paddr == branch_addr);
                    raddr = paddr;
                    pend = 1'b0;
                end else begin
                    cnt = cnt - 1;
                end
            end
            #1;
            if (rst_n) begin
                if (q_push) begin
                    if (!rsp_valid || q_pc !== raddr || q_instr !== instr_of(raddr)) data_viol++;
                    push_log[push_n % 64] = q_pc;
                    push_n++;
                end
                if (req_valid && req_ready) begin
                    if (pend) outst_viol++;
                    if (ni_region && req_spec) spec_viol++;
                    req_log[req_n % 64] = req_addr;
                    spec_log[req_n % 64] = req_spec;
                    req_n++;
                    pend = 1'b1;
                    cnt = LAT - 1;
                    paddr = req_addr;
                end
            end
        end
    end

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse_redirect(logic [31:0] pc);
        redirect_pc = pc;
        redirect_valid = 1'b1;
        @(negedge clk);
        redirect_valid = 1'b0;
    endtask

    task automatic pulse_resolve();
        br_resolve = 1'b1;
        @(negedge clk);
        br_resolve = 1'b0;
    endtask

    task automatic wait_pushes(int base, int n, string tag);
        int k = 0;
        while (push_n - base < n && k < 200) begin
            @(negedge clk);
            k++;
        end
        check(push_n - base >= n, tag, push_n - base, n);
    endtask

    task automatic settle();
        cache_en = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        int seen = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); #2;
            if (req_valid || q_push) seen++;
        end
        check(seen == 0, "R1 quiet before first redirect", seen, 0);
        check(req_n == 0 && push_n == 0, "R1 no traffic", req_n + push_n, 0);
    endtask

    task automatic t_sequential();
        int p0 = push_n;
        int r0 = req_n;
        q_ready = 1'b1; q_free = 3'd4;
        pulse_redirect(32'h100);
        cache_en = 1'b1;
        wait_pushes(p0, 4, "R2 four pushes");
        cache_en = 1'b0;
        for (int i = 0; i < 4; i++)
            check(push_log[(p0 + i) % 64] == 32'h100 + 4 * i, "R2 push order",
                  push_log[(p0 + i) % 64], 32'h100 + 4 * i);
        check(req_log[r0 % 64] == 32'h100, "R8 first request at redirect pc", req_log[r0 % 64], 32'h100);
        check(data_viol == 0, "R2 pushed pc and data match response", data_viol, 0);
        settle();
    endtask

    task automatic t_spec();
        int p0 = push_n;
        int r0 = req_n;
        branch_addr = 32'h204;
        pulse_redirect(32'h200);
        cache_en = 1'b1;
        wait_pushes(p0, 3, "R3 pushes");
        cache_en = 1'b0;
        check(spec_log[(r0 + 1) % 64] == 1'b0, "R3 branch fetch not spec", spec_log[(r0 + 1) % 64], 0);
        check(req_log[(r0 + 2) % 64] == 32'h208 && spec_log[(r0 + 2) % 64] == 1'b1,
              "R3 fetch after branch is spec", {31'd0, spec_log[(r0 + 2) % 64]}, 1);
        pulse_resolve();
        cache_en = 1'b1;
        wait_pushes(p0, 4, "R3 push after resolve");
        cache_en = 1'b0;
        check(req_log[(r0 + 3) % 64] == 32'h20C && spec_log[(r0 + 3) % 64] == 1'b0,
              "R3 resolve clears spec", {31'd0, spec_log[(r0 + 3) % 64]}, 0);
        settle();
    endtask

    task automatic t_ni_spec_block();
        int p0 = push_n;
        int r0 = req_n;
        int seen = 0;
        branch_addr = NI_BASE + 32'h4;
        q_free = 3'd4; q_ready = 1'b1;
        pulse_redirect(NI_BASE);
        cache_en = 1'b1;
        wait_pushes(p0, 2, "R4 ni pushes");
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #2;
            if (req_valid) seen++;
        end
        check(seen == 0, "R4 ni fetch held while spec", seen, 0);
        check(req_n - r0 == 2, "R4 no ni request while spec", req_n - r0, 2);
        pulse_resolve();
        wait_pushes(p0, 3, "R4 ni fetch after resolve");
        cache_en = 1'b0;
        check(req_log[(r0 + 2) % 64] == NI_BASE + 32'h8 && spec_log[(r0 + 2) % 64] == 1'b0,
              "R4 ni fetch issued non-spec", req_log[(r0 + 2) % 64], NI_BASE + 32'h8);
        check(spec_viol == 0, "R4 no spec request to ni", spec_viol, 0);
        settle();
    endtask

    task automatic t_ni_room();
        int p0 = push_n;
        int r0 = req_n;
        int seen = 0;
        int hits = 0;
        q_free = 3'd0; q_ready = 1'b0;
        pulse_redirect(NI_BASE + 32'h40);
        cache_en = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #2;
            if (req_valid) seen++;
        end
        check(seen == 0, "R5 ni fetch held with no free entry", seen, 0);
        @(negedge clk);
        q_free = 3'd1; q_ready = 1'b1;
        wait_pushes(p0, 1, "R5 ni fetch after room");
        cache_en = 1'b0;
        check(push_log[p0 % 64] == NI_BASE + 32'h40, "R5 ni push address", push_log[p0 % 64], NI_BASE + 32'h40);
        for (int i = r0; i < req_n; i++)
            if (req_log[i % 64] == NI_BASE + 32'h40) hits++;
        check(hits == 1, "R9 ni address read once", hits, 1);
        check(outst_viol == 0, "R9 single outstanding", outst_viol, 0);
        q_free = 3'd4;
        settle();
    endtask

    task automatic t_replay();
        int p0 = push_n;
        int r0 = req_n;
        int k = 0;
        q_ready = 1'b0; q_free = 3'd0;
        pulse_redirect(32'h300);
        cache_en = 1'b1;
        while (req_n == r0 && k < 10) begin @(negedge clk); k++; end
        check(req_n - r0 == 1, "R10 idempotent fetch ignores free count", req_n - r0, 1);
        repeat (8) @(negedge clk);
        check(push_n == p0, "R6 no push while queue busy", push_n - p0, 0);
        check(req_n - r0 == 1, "R6 no refetch before ready", req_n - r0, 1);
        q_ready = 1'b1;
        wait_pushes(p0, 1, "R6 push after replay");
        cache_en = 1'b0;
        check(req_log[(r0 + 1) % 64] == 32'h300, "R6 refetch same address", req_log[(r0 + 1) % 64], 32'h300);
        repeat (2) @(negedge clk);
        check(push_n - p0 == 1 && push_log[p0 % 64] == 32'h300, "R6 pushed exactly once",
              push_n - p0, 1);
        q_free = 3'd4;
        settle();
    endtask

    task automatic t_branch_replay();
        int p0 = push_n;
        int r0 = req_n;
        branch_addr = 32'h404;
        q_ready = 1'b0;
        pulse_redirect(32'h404);
        cache_en = 1'b1;
        repeat (8) @(negedge clk);
        q_ready = 1'b1;
        wait_pushes(p0, 2, "R7 pushes");
        cache_en = 1'b0;
        check(req_log[(r0 + 1) % 64] == 32'h404 && spec_log[(r0 + 1) % 64] == 1'b0,
              "R7 replayed branch refetch non-spec", {31'd0, spec_log[(r0 + 1) % 64]}, 0);
        check(spec_log[(r0 + 2) % 64] == 1'b1, "R3 spec after pushed branch",
              {31'd0, spec_log[(r0 + 2) % 64]}, 1);
        settle();
    endtask

    task automatic t_redirect_drop();
        int p0 = push_n;
        int r0 = req_n;
        int k = 0;
        branch_addr = 32'h1;
        q_ready = 1'b1;
        redirect_pc = 32'h500;
        redirect_valid = 1'b0;
        cache_en = 1'b1;
        while (req_n == r0 && k < 10) begin @(negedge clk); k++; end
        check(req_log[r0 % 64][31:8] == 24'h0004, "R8 stale request issued spec",
              {31'd0, spec_log[r0 % 64]}, 1);
        pulse_redirect(32'h600);
        wait_pushes(p0, 1, "R8 push after redirect");
        cache_en = 1'b0;
        check(push_log[p0 % 64] == 32'h600, "R8 in-flight response dropped", push_log[p0 % 64], 32'h600);
        check(req_log[(r0 + 1) % 64] == 32'h600 && spec_log[(r0 + 1) % 64] == 1'b0,
              "R8 redirect clears spec", {31'd0, spec_log[(r0 + 1) % 64]}, 0);
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sequential();
        t_spec();
        t_ni_spec_block();
        t_ni_room();
        t_replay();
        t_branch_replay();
        t_redirect_drop();
        check(spec_viol == 0 && outst_viol == 0, "R9 global protocol", spec_viol + outst_viol, 0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule